// File: doc/BRIEF.md
# Direct-Mapped Cache with Victim Buffer

This block is a direct-mapped data cache paired with a small fully associative side buffer that catches lines pushed out of the main array. The processor side accepts one word-addressed read or write at a time and answers with a single-cycle response pulse. The memory side moves whole lines through one request channel, which carries both write-backs and refill reads, and one response channel that returns refill data.

Every access first probes the direct-mapped slot chosen by the index bits. On a miss there, the side buffer is searched by full line address. A hit in the buffer exchanges the two lines, so the requested line lands in the main slot and the line it displaces takes the freed buffer entry. A miss in both fetches the line from memory. The line displaced from the main slot is then demoted into the buffer, and an entry that has to leave the buffer is written to memory only when it is dirty.

Line size, number of sets, word width and buffer depth are parameters. The word address splits, from the most significant end, into tag, index and word offset.

Top module: `dm_victim_cache`

## Requirements
- R1: After reset both structures hold no valid line, `cpuReqReady` is 1, and neither `cpuRspValid` nor `memReqValid` is asserted. The first access to any address therefore misses.
- R2: A read or write that hits the direct-mapped array raises `cpuRspValid` in the cycle after the request is accepted. Only one request is in flight, and `cpuReqReady` stays low until its response.
- R3: An access that misses the array but hits the side buffer responds two cycles after acceptance and makes no memory request. Afterwards the requested line hits the array in one cycle, and the line it displaced is found in the buffer in two.
- R4: An access that misses both structures issues one line read for its line address (`memReqAddr` = word address without the offset bits). It responds only after the refill, and the line that was in the main slot is then held in the buffer.
- R5: A line entering the buffer takes the lowest-numbered invalid entry if one exists. Otherwise it replaces the entry inserted longest ago among valid entries, and a swap does not change that order.
- R6: A dirty line leaving the buffer is written to memory, with `memReqWrite` = 1, its own line address and its contents, before the refill read that caused its removal. A clean line leaving the buffer is dropped without any memory write.
- R7: A write stores `cpuReqWdata` into the selected word and marks the line dirty. The dirty mark moves with the line through swaps and demotions, so the data reaches memory when the line finally leaves the buffer.
- R8: Once `memReqValid` is raised it stays high with unchanged `memReqAddr` and `memReqWrite` until `memReqReady` is seen.
- R9: A read returns the word selected by the offset bits, where word i of a line occupies bits [i*DATA_W +: DATA_W] of the line bus. Read data always equals the most recent value written to that address, or the memory contents if it was never written.
- R10: `cpuRspValid` is a single-cycle pulse per accepted request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Asynchronous reset, active low |
| cpuReqValid | input | 1 | Processor request present |
| cpuReqReady | output | 1 | Block can accept a request this cycle |
| cpuReqWrite | input | 1 | 1 = write, 0 = read |
| cpuReqAddr | input | ADDR_W | Word address {tag, index, offset} |
| cpuReqWdata | input | DATA_W | Write data |
| cpuRspValid | output | 1 | Response pulse |
| cpuRspRdata | output | DATA_W | Read data, valid with the pulse for reads |
| memReqValid | output | 1 | Memory request present |
| memReqReady | input | 1 | Memory takes the request this cycle |
| memReqWrite | output | 1 | 1 = line write-back, 0 = line read |
| memReqAddr | output | ADDR_W-log2(WORDS_PER_LINE) | Line address |
| memReqData | output | DATA_W*WORDS_PER_LINE | Write-back line |
| memRspValid | input | 1 | Refill line present, one cycle |
| memRspData | input | DATA_W*WORDS_PER_LINE | Refill line |

## Verification
The cycle that finishes a refill does two jobs at once. It demotes the displaced line into a buffer entry and installs the fetched line in the main slot, and that entry may have been emptied by a write-back one or two transactions earlier. The bench provokes this by streaming conflicting lines through one set after marking some of them dirty. This fills the buffer and forces both clean drops and dirty write-backs. The outcome is judged by the count of memory writes, by the written-back words in the bench's memory image, and by every later read, which must agree with a reference image kept from the writes alone.

// File: rtl/dm_victim_cache_pkg.sv
package dm_victim_cache_pkg;

  typedef struct packed {
    logic latchReq;
    logic doWrite;
    logic doSwap;
    logic latchVictim;
    logic doFill;
    logic wbSel;
  } vcCtrl_t;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_LOOK,
    ST_WB,
    ST_RD,
    ST_WAIT
  } vcState_t;

endpackage

// File: rtl/dm_victim_cache_ctrl.sv
module dm_victim_cache_ctrl
  import dm_victim_cache_pkg::*;
(
  input  logic    clk,
  input  logic    rstN,
  input  logic    cpuReqValid,
  input  logic    dmHit,
  input  logic    vbHit,
  input  logic    victimDirty,
  input  logic    reqIsWrite,
  input  logic    memReqReady,
  input  logic    memRspValid,
  output vcCtrl_t ctrl,
  output logic    cpuReqReady,
  output logic    cpuRspValid,
  output logic    memReqValid,
  output logic    memReqWrite
);

  vcState_t state, nextState;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) state <= ST_IDLE;
    else       state <= nextState;
  end

  always_comb begin
    ctrl        = '0;
    nextState   = state;
    cpuReqReady = 1'b0;
    cpuRspValid = 1'b0;
    memReqValid = 1'b0;
    memReqWrite = 1'b0;
    case (state)
      ST_IDLE: begin
        cpuReqReady = 1'b1;
        if (cpuReqValid) begin
          ctrl.latchReq = 1'b1;
          nextState     = ST_LOOK;
        end
      end
      ST_LOOK: begin
        if (dmHit) begin
          cpuRspValid  = 1'b1;
          ctrl.doWrite = reqIsWrite;
          nextState    = ST_IDLE;
        end else if (vbHit) begin
          ctrl.doSwap = 1'b1;
        end else begin
          ctrl.latchVictim = 1'b1;
          nextState        = victimDirty ? ST_WB : ST_RD;
        end
      end
      ST_WB: begin
        memReqValid = 1'b1;
        memReqWrite = 1'b1;
        ctrl.wbSel  = 1'b1;
        if (memReqReady) nextState = ST_RD;
      end
      ST_RD: begin
        memReqValid = 1'b1;
        if (memReqReady) nextState = ST_WAIT;
      end
      ST_WAIT: begin
        if (memRspValid) begin
          ctrl.doFill = 1'b1;
          nextState   = ST_LOOK;
        end
      end
      default: nextState = ST_IDLE;
    endcase
  end

endmodule

// File: rtl/dm_victim_cache_dp.sv
module dm_victim_cache_dp
  import dm_victim_cache_pkg::*;
#(
  parameter int ADDR_W         = 12,
  parameter int DATA_W         = 32,
  parameter int WORDS_PER_LINE = 4,
  parameter int SETS           = 16,
  parameter int VB_DEPTH       = 4,
  localparam int OFF_W         = $clog2(WORDS_PER_LINE),
  localparam int IDX_W         = $clog2(SETS),
  localparam int LINE_ADDR_W   = ADDR_W - OFF_W,
  localparam int TAG_W         = LINE_ADDR_W - IDX_W,
  localparam int LINE_W        = DATA_W * WORDS_PER_LINE,
  localparam int VB_IDX_W      = $clog2(VB_DEPTH)
)(
  input  logic                   clk,
  input  logic                   rstN,
  input  vcCtrl_t                ctrl,
  input  logic [ADDR_W-1:0]      cpuReqAddr,
  input  logic                   cpuReqWrite,
  input  logic [DATA_W-1:0]      cpuReqWdata,
  input  logic [LINE_W-1:0]      memRspData,
  output logic                   dmHit,
  output logic                   vbHit,
  output logic                   victimDirty,
  output logic                   reqIsWrite,
  output logic [DATA_W-1:0]      cpuRspRdata,
  output logic [LINE_ADDR_W-1:0] memReqAddr,
  output logic [LINE_W-1:0]      memReqData
);

  // latched request and its fields
  logic [ADDR_W-1:0]      reqAddr;
  logic [DATA_W-1:0]      reqWdata;
  logic [OFF_W-1:0]       reqOff;
  logic [LINE_ADDR_W-1:0] reqLine;
  logic [IDX_W-1:0]       reqIdx;
  logic [TAG_W-1:0]       reqTag;

  assign reqOff  = reqAddr[OFF_W-1:0];
  assign reqLine = reqAddr[ADDR_W-1:OFF_W];
  assign reqIdx  = reqLine[IDX_W-1:0];
  assign reqTag  = reqLine[LINE_ADDR_W-1:IDX_W];

  // direct-mapped array
  logic [SETS-1:0]   dmValid, dmDirty;
  logic [TAG_W-1:0]  dmTag  [SETS];
  logic [LINE_W-1:0] dmData [SETS];

  // victim buffer
  logic [VB_DEPTH-1:0]    vbValid, vbDirty, vbMatch;
  logic [LINE_ADDR_W-1:0] vbAddr [VB_DEPTH];
  logic [LINE_W-1:0]      vbData [VB_DEPTH];
  logic [VB_IDX_W-1:0]    vbPtr, vbSelQ, vbHitIdx, vbFreeIdx, vbChoice, vbSelNext;
  logic                   vbHasFree;

  for (genvar g = 0; g < VB_DEPTH; g++) begin : gMatch
    assign vbMatch[g] = vbValid[g] && (vbAddr[g] == reqLine);
  end

  always_comb begin
    vbHitIdx  = '0;
    vbFreeIdx = '0;
    vbHasFree = 1'b0;
    for (int i = VB_DEPTH - 1; i >= 0; i--) begin
      if (vbMatch[i]) vbHitIdx = VB_IDX_W'(i);
      if (!vbValid[i]) begin
        vbHasFree = 1'b1;
        vbFreeIdx = VB_IDX_W'(i);
      end
    end
  end

  assign vbChoice  = vbHasFree ? vbFreeIdx : vbPtr;
  assign vbSelNext = (vbSelQ == VB_IDX_W'(VB_DEPTH - 1)) ? '0 : vbSelQ + 1'b1;

  assign dmHit       = dmValid[reqIdx] && (dmTag[reqIdx] == reqTag);
  assign vbHit       = |vbMatch;
  assign victimDirty = dmValid[reqIdx] && vbValid[vbChoice] && vbDirty[vbChoice];
  assign cpuRspRdata = dmData[reqIdx][reqOff*DATA_W +: DATA_W];
  assign memReqAddr  = ctrl.wbSel ? vbAddr[vbSelQ] : reqLine;
  assign memReqData  = vbData[vbSelQ];

  // state bits with reset
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      reqAddr    <= '0;
      reqWdata   <= '0;
      reqIsWrite <= 1'b0;
      dmValid    <= '0;
      dmDirty    <= '0;
      vbValid    <= '0;
      vbDirty    <= '0;
      vbPtr      <= '0;
      vbSelQ     <= '0;
    end else begin
      if (ctrl.latchReq) begin
        reqAddr    <= cpuReqAddr;
        reqWdata   <= cpuReqWdata;
        reqIsWrite <= cpuReqWrite;
      end
      if (ctrl.latchVictim) vbSelQ <= vbChoice;
      if (ctrl.doSwap) begin
        vbValid[vbHitIdx] <= dmValid[reqIdx];
        vbDirty[vbHitIdx] <= dmDirty[reqIdx];
        dmValid[reqIdx]   <= 1'b1;
        dmDirty[reqIdx]   <= vbDirty[vbHitIdx];
      end
      if (ctrl.doFill) begin
        if (dmValid[reqIdx]) begin
          vbValid[vbSelQ] <= 1'b1;
          vbDirty[vbSelQ] <= dmDirty[reqIdx];
          if (vbValid[vbSelQ]) vbPtr <= vbSelNext;
        end
        dmValid[reqIdx] <= 1'b1;
        dmDirty[reqIdx] <= 1'b0;
      end
      if (ctrl.doWrite) dmDirty[reqIdx] <= 1'b1;
    end
  end

  // tag and data storage, no reset
  always_ff @(posedge clk) begin
    if (ctrl.doSwap) begin
      vbAddr[vbHitIdx] <= {dmTag[reqIdx], reqIdx};
      vbData[vbHitIdx] <= dmData[reqIdx];
      dmTag[reqIdx]    <= vbAddr[vbHitIdx][LINE_ADDR_W-1:IDX_W];
      dmData[reqIdx]   <= vbData[vbHitIdx];
    end
    if (ctrl.doFill) begin
      if (dmValid[reqIdx]) begin
        vbAddr[vbSelQ] <= {dmTag[reqIdx], reqIdx};
        vbData[vbSelQ] <= dmData[reqIdx];
      end
      dmTag[reqIdx]  <= reqTag;
      dmData[reqIdx] <= memRspData;
    end
    if (ctrl.doWrite) dmData[reqIdx][reqOff*DATA_W +: DATA_W] <= reqWdata;
  end

endmodule

// File: rtl/dm_victim_cache.sv
module dm_victim_cache
  import dm_victim_cache_pkg::*;
#(
  parameter int ADDR_W         = 12,
  parameter int DATA_W         = 32,
  parameter int WORDS_PER_LINE = 4,
  parameter int SETS           = 16,
  parameter int VB_DEPTH       = 4,
  localparam int LINE_ADDR_W   = ADDR_W - $clog2(WORDS_PER_LINE),
  localparam int LINE_W        = DATA_W * WORDS_PER_LINE
)(
  input  logic                   clk,
  input  logic                   rstN,
  input  logic                   cpuReqValid,
  output logic                   cpuReqReady,
  input  logic                   cpuReqWrite,
  input  logic [ADDR_W-1:0]      cpuReqAddr,
  input  logic [DATA_W-1:0]      cpuReqWdata,
  output logic                   cpuRspValid,
  output logic [DATA_W-1:0]      cpuRspRdata,
  output logic                   memReqValid,
  input  logic                   memReqReady,
  output logic                   memReqWrite,
  output logic [LINE_ADDR_W-1:0] memReqAddr,
  output logic [LINE_W-1:0]      memReqData,
  input  logic                   memRspValid,
  input  logic [LINE_W-1:0]      memRspData
);

  vcCtrl_t ctrl;
  logic    dmHit, vbHit, victimDirty, reqIsWrite;

  dm_victim_cache_ctrl u_ctrl (
    .clk         (clk),
    .rstN        (rstN),
    .cpuReqValid (cpuReqValid),
    .dmHit       (dmHit),
    .vbHit       (vbHit),
    .victimDirty (victimDirty),
    .reqIsWrite  (reqIsWrite),
    .memReqReady (memReqReady),
    .memRspValid (memRspValid),
    .ctrl        (ctrl),
    .cpuReqReady (cpuReqReady),
    .cpuRspValid (cpuRspValid),
    .memReqValid (memReqValid),
    .memReqWrite (memReqWrite)
  );

  dm_victim_cache_dp #(
    .ADDR_W         (ADDR_W),
    .DATA_W         (DATA_W),
    .WORDS_PER_LINE (WORDS_PER_LINE),
    .SETS           (SETS),
    .VB_DEPTH       (VB_DEPTH)
  ) u_dp (
    .clk         (clk),
    .rstN        (rstN),
    .ctrl        (ctrl),
    .cpuReqAddr  (cpuReqAddr),
    .cpuReqWrite (cpuReqWrite),
    .cpuReqWdata (cpuReqWdata),
    .memRspData  (memRspData),
    .dmHit       (dmHit),
    .vbHit       (vbHit),
    .victimDirty (victimDirty),
    .reqIsWrite  (reqIsWrite),
    .cpuRspRdata (cpuRspRdata),
    .memReqAddr  (memReqAddr),
    .memReqData  (memReqData)
  );

endmodule

// File: rtl/dm_victim_cache_chk.sv
module dm_victim_cache_chk #(
  parameter int LINE_ADDR_W = 10
)(
  input logic                   clk,
  input logic                   rstN,
  input logic                   cpuReqValid,
  input logic                   cpuReqReady,
  input logic                   cpuRspValid,
  input logic                   memReqValid,
  input logic                   memReqReady,
  input logic                   memReqWrite,
  input logic [LINE_ADDR_W-1:0] memReqAddr
);

  logic busy;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                           busy <= 1'b0;
    else if (cpuReqValid && cpuReqReady) busy <= 1'b1;
    else if (cpuRspValid)                busy <= 1'b0;
  end

  AST_RSP_HAS_REQ: assert property (@(posedge clk) disable iff (!rstN)
    cpuRspValid |-> busy); // R2
  AST_SINGLE_INFLIGHT: assert property (@(posedge clk) disable iff (!rstN)
    busy |-> !cpuReqReady); // R2
  AST_RSP_PULSE: assert property (@(posedge clk) disable iff (!rstN)
    cpuRspValid |=> !cpuRspValid); // R10
  AST_MEM_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    memReqValid && !memReqReady |=> memReqValid && $stable(memReqAddr) && $stable(memReqWrite)); // R8
  AST_WB_THEN_FETCH: assert property (@(posedge clk) disable iff (!rstN)
    memReqValid && memReqWrite && memReqReady |=> memReqValid && !memReqWrite); // R6
  AST_IDLE_NO_MEM: assert property (@(posedge clk) disable iff (!rstN)
    cpuReqReady |-> !memReqValid); // R1

endmodule

bind dm_victim_cache dm_victim_cache_chk #(.LINE_ADDR_W(LINE_ADDR_W)) u_chk (
  .clk         (clk),
  .rstN        (rstN),
  .cpuReqValid (cpuReqValid),
  .cpuReqReady (cpuReqReady),
  .cpuRspValid (cpuRspValid),
  .memReqValid (memReqValid),
  .memReqReady (memReqReady),
  .memReqWrite (memReqWrite),
  .memReqAddr  (memReqAddr)
);

// File: tb/dm_victim_cache_bench.sv
`timescale 1ns/1ps
module dm_victim_cache_bench;

  logic         clk = 1'b0;
  logic         rstN = 1'b0;
  logic         cpuReqValid = 1'b0, cpuReqWrite = 1'b0;
  logic [11:0]  cpuReqAddr = '0;
  logic [31:0]  cpuReqWdata = '0;
  logic         cpuReqReady, cpuRspValid;
  logic [31:0]  cpuRspRdata;
  logic         memReqValid, memReqWrite;
  logic         memReqReady = 1'b0;
  logic [9:0]   memReqAddr;
  logic [127:0] memReqData;
  logic         memRspValid = 1'b0;
  logic [127:0] memRspData = '0;

  always #4 clk = ~clk;

  dm_victim_cache u_dm_victim_cache (
    .clk(clk), .rstN(rstN),
    .cpuReqValid(cpuReqValid), .cpuReqReady(cpuReqReady), .cpuReqWrite(cpuReqWrite),
    .cpuReqAddr(cpuReqAddr), .cpuReqWdata(cpuReqWdata),
    .cpuRspValid(cpuRspValid), .cpuRspRdata(cpuRspRdata),
    .memReqValid(memReqValid), .memReqReady(memReqReady), .memReqWrite(memReqWrite),
    .memReqAddr(memReqAddr), .memReqData(memReqData),
    .memRspValid(memRspValid), .memRspData(memRspData)
  );

  logic [31:0] memArr [4096];
  logic [31:0] refMem [4096];
  int checks = 0, fails = 0, memReads = 0, memWrites = 0;
  bit done = 0;

  function automatic logic [11:0] mk(int tag, int idx, int off);
    return 12'((tag << 6) | (idx << 2) | off);
  endfunction

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  // behavioural next-level memory
  initial begin
    int pend = 0;
    int tick = 0;
    logic [9:0] rdLine = '0;
    for (int i = 0; i < 4096; i++) begin
      memArr[i] = 32'(i) * 32'h0100_0193 + 32'h5a5a_0000;
      refMem[i] = memArr[i];
    end
    forever begin
      @(negedge clk);
      memRspValid = 1'b0;
      if (pend > 0) begin
        pend--;
        if (pend == 0) begin
          memRspValid = 1'b1;
          for (int w = 0; w < 4; w++) memRspData[w*32 +: 32] = memArr[{rdLine, 2'(w)}];
        end
      end
      tick++;
      memReqReady = (tick % 3) != 1;
      if (rstN && memReqValid && memReqReady) begin
        if (memReqWrite) begin
          for (int w = 0; w < 4; w++) memArr[{memReqAddr, 2'(w)}] = memReqData[w*32 +: 32];
          memWrites++;
        end else begin
          memReads++;
          rdLine = memReqAddr;
          pend = 2;
        end
      end
    end
  end

  task automatic access(input bit wr, input logic [11:0] a, input logic [31:0] d,
                        output int lat, output logic [31:0] rd);
    @(negedge clk);
    cpuReqValid = 1'b1; cpuReqWrite = wr; cpuReqAddr = a; cpuReqWdata = d;
    while (!cpuReqReady) @(negedge clk);
    @(negedge clk);
    cpuReqValid = 1'b0;
    lat = 1;
    while (!cpuRspValid && lat < 1000) begin
      @(negedge clk);
      lat++;
    end
    rd = cpuRspRdata;
    if (wr) refMem[a] = d;
  endtask

  task automatic rdChk(input string req, input logic [11:0] a, output int lat);
    logic [31:0] rd;
    access(1'b0, a, '0, lat, rd);
    chk(req, rd, refMem[a]);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    int lat, r0, w0;
    logic [31:0] rd;
    logic [15:0] lfsr = 16'hACE1;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk("R1 ready after reset", cpuReqReady, 1);
    chk("R1 no response after reset", cpuRspValid, 0);
    chk("R1 no memory request after reset", memReqValid, 0);

    // R4 first access misses, R9 word select
    r0 = memReads;
    rdChk("R9 refill word", mk(1, 0, 2), lat);
    chk("R1 R4 first access misses", lat > 2, 1);
    chk("R4 one line read", memReads - r0, 1);
    // R2 hit in one cycle
    rdChk("R9 hit word", mk(1, 0, 3), lat);
    chk("R2 hit latency", lat, 1);
    @(negedge clk);
    chk("R10 response is a pulse", cpuRspValid, 0);

    // R3 swap behaviour
    rdChk("R4 conflict refill", mk(2, 0, 0), lat);
    chk("R4 conflict misses", lat > 2, 1);
    r0 = memReads;
    rdChk("R3 buffer data", mk(1, 0, 1), lat);
    chk("R3 buffer hit latency", lat, 2);
    chk("R3 buffer hit no memory read", memReads - r0, 0);
    rdChk("R3 swapped line", mk(1, 0, 0), lat);
    chk("R3 swapped line now one cycle", lat, 1);
    rdChk("R4 demoted line", mk(2, 0, 2), lat);
    chk("R4 demoted line in buffer", lat, 2);

    // R7 write hit
    access(1'b1, mk(2, 0, 1), 32'hDEAD_0001, lat, rd);
    chk("R7 write hit latency", lat, 1);
    rdChk("R7 write readback", mk(2, 0, 1), lat);

    // R6 clean drop and dirty write-back, R5 order
    for (int t = 3; t <= 6; t++) rdChk("R4 fill stream", mk(t, 0, 0), lat);
    chk("R6 clean lines dropped silently", memWrites, 0);
    w0 = memWrites;
    rdChk("R6 stream miss", mk(7, 0, 0), lat);
    chk("R6 dirty eviction writes once", memWrites - w0, 1);
    chk("R6 written-back word", memArr[mk(2, 0, 1)], 32'hDEAD_0001);
    rdChk("R5 recent entry kept", mk(4, 0, 1), lat);
    chk("R5 recent entry hit", lat, 2);
    rdChk("R5 recent entry kept 2", mk(3, 0, 2), lat);
    chk("R5 recent entry hit 2", lat, 2);
    rdChk("R5 oldest entry gone", mk(1, 0, 3), lat);
    chk("R5 oldest entry misses", lat > 2, 1);
    rdChk("R6 reread after write-back", mk(2, 0, 1), lat);

    // R7 dirty bit travels through swap
    access(1'b1, mk(8, 1, 2), 32'hBEEF_0008, lat, rd);
    rdChk("R7 conflict", mk(9, 1, 0), lat);
    rdChk("R7 dirty via buffer", mk(8, 1, 2), lat);
    chk("R7 dirty line buffer hit", lat, 2);
    for (int t = 10; t <= 15; t++) rdChk("R7 push stream", mk(t, 1, 1), lat);
    chk("R7 dirty carried to memory", memArr[mk(8, 1, 2)], 32'hBEEF_0008);

    // sweep over a small conflict pool
    for (int n = 0; n < 600; n++) begin
      logic [11:0] a;
      lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
      a = mk(int'(lfsr[2:0]), int'(lfsr[3]), int'(lfsr[5:4]));
      if (lfsr[7:6] == 2'b00) access(1'b1, a, {lfsr, 16'(n)}, lat, rd);
      else rdChk("R9 sweep read", a, lat);
    end
    for (int t = 0; t < 8; t++)
      for (int i = 0; i < 2; i++)
        for (int o = 0; o < 4; o++) rdChk("R9 final read", mk(t, i, o), lat);

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

endmodule